// File: doc/BRIEF.md
# Configurable External Event Glitch Filter

This block cleans up one asynchronous external event line before the rest of the chip acts on it. The raw line is first brought into the kernel clock domain through a chain of flops. The resynchronised level is then sampled at a programmable rate, and a counter tracks how many consecutive samples disagree with the level currently driven out. The output changes only when that run of disagreeing samples reaches a programmed length. Shorter pulses and bursts of ringing are discarded.

A single 4-bit configuration code sets both the sampling rate and the required run length. Code 0 turns the filter off, and the resynchronised level is registered straight to the output. Codes 1 to 3 sample on every kernel clock. Codes 4 to 15 sample on a power-of-two division, from 2 to 32, of a separate event-sampling clock. That clock arrives as a one-cycle enable pulse in the kernel domain. The run length is taken from a small fixed table, so downstream logic sees a cleaned level with a latency it can predict.

Top module: `evt_glitch_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, the output is 0. Reset clears the sample counter and the divider.
- R2: The raw input passes through two synchroniser flops before any use. With code 0, the output equals the raw input as it stood three rising edges earlier.
- R3: Code 0 bypasses filtering. Sampling-enable pulses have no effect on the output in this mode.
- R4: Codes 1, 2 and 3 take one sample on every kernel clock and need 2, 4 and 8 consecutive opposite samples. When the raw input changes and then holds, the output follows on rising edge 2+N after the change.
- R5: Codes 4 to 9 sample once for every D enable pulses and need N samples. The pairs (D, N) are 4:(2,6), 5:(2,8), 6:(4,6), 7:(4,8), 8:(8,6) and 9:(8,8). After a restart with the input already settled, the output changes on enable pulse D*N.
- R6: Codes 10 to 15 use the same counting rule. The pairs (D, N) are 10:(16,5), 11:(16,6), 12:(16,8), 13:(32,5), 14:(32,6) and 15:(32,8).
- R7: A sample equal to the current output clears the counter. Only an unbroken run of N opposite samples changes the output, so with code 3 a high run of 5 samples, one low sample and another run of 5 leave the output at 0.
- R8: In the divided modes (codes 4 to 15) only enable pulses advance sampling. With no pulses, the output holds its value however long the input stays changed.
- R9: A change of code restarts the divider and the counter and leaves the output unchanged. After a switch from code 5, made 3 pulses in, to code 7, the output changes on exactly the 32nd following pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_raw_i | input | 1 | Asynchronous raw event level |
| smp_en_i | input | 1 | One-cycle event-sampling clock enable pulse |
| cfg_code_i | input | 4 | Filter configuration code |
| evt_filt_o | output | 1 | Filtered event level |

## Verification
The bench builds the block with its default parameters: a two-flop synchroniser, a 4-bit run counter and a 5-bit divider. These widths reach the longest run in the table (8 samples) and the deepest division (32 pulses), so the bench can sweep every one of the sixteen codes to its exact D*N or 2+N latency. Those codes include the 256-pulse case of code 15. A random phase then mixes input toggles, sparse enable pulses and occasional code changes. It is compared cycle by cycle against a bench model, which exposes restarts that happen in the middle of a run or with the divider part-way through its count.

// File: rtl/evt_filt_pkg.sv
package evt_filt_pkg;

    localparam int CODE_W = 4;
    localparam int NEED_W = 4;
    localparam int DLOG_W = 3;

    typedef struct packed {
        logic              bypass;
        logic              kern;
        logic [DLOG_W-1:0] dlog;
        logic [NEED_W-1:0] need;
    } filt_cfg_t;

    function automatic filt_cfg_t cfg_decode(input logic [CODE_W-1:0] code);
        filt_cfg_t c;
        c = '{bypass: 1'b0, kern: 1'b0, dlog: 3'd0, need: 4'd1};
        case (code)
            4'd0:  c.bypass = 1'b1;
            4'd1:  begin c.kern = 1'b1; c.need = 4'd2; end
            4'd2:  begin c.kern = 1'b1; c.need = 4'd4; end
            4'd3:  begin c.kern = 1'b1; c.need = 4'd8; end
            4'd4:  begin c.dlog = 3'd1; c.need = 4'd6; end
            4'd5:  begin c.dlog = 3'd1; c.need = 4'd8; end
            4'd6:  begin c.dlog = 3'd2; c.need = 4'd6; end
            4'd7:  begin c.dlog = 3'd2; c.need = 4'd8; end
            4'd8:  begin c.dlog = 3'd3; c.need = 4'd6; end
            4'd9:  begin c.dlog = 3'd3; c.need = 4'd8; end
            4'd10: begin c.dlog = 3'd4; c.need = 4'd5; end
            4'd11: begin c.dlog = 3'd4; c.need = 4'd6; end
            4'd12: begin c.dlog = 3'd4; c.need = 4'd8; end
            4'd13: begin c.dlog = 3'd5; c.need = 4'd5; end
            4'd14: begin c.dlog = 3'd5; c.need = 4'd6; end
            default: begin c.dlog = 3'd5; c.need = 4'd8; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain[0] <= 1'b0;
                    else       chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain[g] <= 1'b0;
                    else       chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
    import evt_filt_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              restart_i,
    input  logic              kern_i,
    input  logic [DLOG_W-1:0] dlog_i,
    input  logic              pulse_i,
    output logic              stb_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_last;
    logic             wrap;

    assign div_last = DIV_W'((32'd1 << dlog_i) - 32'd1);
    assign wrap     = pulse_i && (div_q == div_last);
    assign stb_o    = !restart_i && (kern_i || wrap);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i || kern_i) begin
            div_q <= '0;
        end else if (pulse_i) begin
            div_q <= wrap ? '0 : div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/evt_run_counter.sv
module evt_run_counter
    import evt_filt_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              restart_i,
    input  logic              bypass_i,
    input  logic [NEED_W-1:0] need_i,
    input  logic              stb_i,
    input  logic              smp_i,
    output logic              lvl_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             lvl_q;

    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (bypass_i) begin
            cnt_q <= '0;
            lvl_q <= smp_i;
        end else if (stb_i) begin
            if (smp_i == lvl_q) begin
                cnt_q <= '0;
            end else if (cnt_inc == CNT_W'(need_i)) begin
                cnt_q <= '0;
                lvl_q <= smp_i;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/evt_glitch_filter.sv
module evt_glitch_filter
    import evt_filt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int DIV_W       = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              evt_raw_i,
    input  logic              smp_en_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    output logic              evt_filt_o
);
    filt_cfg_t         cfg;
    logic [CODE_W-1:0] code_prev;
    logic              code_chg;
    logic              sync_lvl;
    logic              smp_stb;

    assign cfg      = cfg_decode(cfg_code_i);
    assign code_chg = (cfg_code_i != code_prev);

    always_ff @(posedge clk_i) begin
        if (rst_i) code_prev <= '0;
        else       code_prev <= cfg_code_i;
    end

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (evt_raw_i),
        .q_o   (sync_lvl)
    );

    evt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (code_chg),
        .kern_i    (cfg.kern),
        .dlog_i    (cfg.dlog),
        .pulse_i   (smp_en_i),
        .stb_o     (smp_stb)
    );

    evt_run_counter #(.CNT_W(CNT_W)) u_run (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (code_chg),
        .bypass_i  (cfg.bypass),
        .need_i    (cfg.need),
        .stb_i     (smp_stb),
        .smp_i     (sync_lvl),
        .lvl_o     (evt_filt_o)
    );
endmodule

// File: rtl/evt_glitch_filter_chk.sv
module evt_glitch_filter_chk (
    input logic clk,
    input logic rst,
    input logic smp_en,
    input logic filt,
    input logic sync_lvl,
    input logic smp_stb,
    input logic code_chg,
    input logic cfg_bypass,
    input logic cfg_kern
);
    assert_reset_low_R1: assert property (@(posedge clk) rst |=> !filt);

    assert_bypass_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_bypass && !code_chg) |=> (filt == $past(sync_lvl)));

    assert_kernel_every_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_kern && !code_chg) |-> smp_stb);

    assert_change_needs_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(filt) && !$past(cfg_bypass)) |-> $past(smp_stb));

    assert_strobe_needs_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !cfg_kern) |-> smp_en);

    assert_code_change_hold_R9: assert property (@(posedge clk) disable iff (rst)
        code_chg |=> $stable(filt));
endmodule

bind evt_glitch_filter evt_glitch_filter_chk u_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .smp_en     (smp_en_i),
    .filt       (evt_filt_o),
    .sync_lvl   (sync_lvl),
    .smp_stb    (smp_stb),
    .code_chg   (code_chg),
    .cfg_bypass (cfg.bypass),
    .cfg_kern   (cfg.kern)
);

// File: tb/sim_evt_glitch_filter.sv
module sim_evt_glitch_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw = 1'b0;
    logic       en  = 1'b0;
    logic [3:0] code = 4'd0;
    logic       filt;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    evt_glitch_filter u0 (
        .clk_i(clk), .rst_i(rst), .evt_raw_i(raw), .smp_en_i(en),
        .cfg_code_i(code), .evt_filt_o(filt)
    );

    function automatic int exp_need(input logic [3:0] c);
        case (c)
            4'd0: return 0;
            4'd1: return 2;
            4'd2: return 4;
            4'd10, 4'd13: return 5;
            4'd4, 4'd6, 4'd8, 4'd11, 4'd14: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_div(input logic [3:0] c);
        if (c <= 4'd3) return 1;
        if (c <= 4'd5) return 2;
        if (c <= 4'd7) return 4;
        if (c <= 4'd9) return 8;
        if (c <= 4'd12) return 16;
        return 32;
    endfunction

    // behavioural reference built from the requirements
    logic m_s1, m_s2, m_out;
    logic [3:0] m_prev;
    int m_cnt, m_div;
    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_out <= 0; m_prev <= 0; m_cnt <= 0; m_div <= 0;
        end else begin
            m_s1 <= raw; m_s2 <= m_s1; m_prev <= code;
            if (code != m_prev) begin
                m_cnt <= 0; m_div <= 0;
            end else if (code == 4'd0) begin
                m_out <= m_s2; m_cnt <= 0;
            end else begin
                automatic bit take = (code <= 4'd3);
                if (code > 4'd3 && en) begin
                    if (m_div == exp_div(code) - 1) begin take = 1; m_div <= 0; end
                    else m_div <= m_div + 1;
                end
                if (take) begin
                    if (m_s2 == m_out) m_cnt <= 0;
                    else if (m_cnt + 1 == exp_need(code)) begin m_cnt <= 0; m_out <= m_s2; end
                    else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (model_on) chk(filt == m_out, "R5 R6 model compare", filt, m_out);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic force_low();
        code = 4'd0; raw = 1'b0; en = 1'b0;
        steps(6);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                summary();
            end
        end
    end

    initial begin
        int n;
        @(negedge clk);
        chk(filt == 1'b0, "R1 output during reset", filt, 0);
        steps(3);
        rst = 1'b0;
        step();
        chk(filt == 1'b0, "R1 output after reset", filt, 0);

        // R2 bypass latency
        force_low();
        raw = 1'b1;
        n = 0;
        while (filt != 1'b1 && n < 20) begin step(); n++; end
        chk(n == 3, "R2 bypass latency", n, 3);

        // R3 enable pulses ignored in bypass
        for (int i = 0; i < 8; i++) begin en = i[0]; step(); end
        en = 1'b0;
        chk(filt == 1'b1, "R3 bypass ignores enable", filt, 1);
        raw = 1'b0;
        steps(3);
        chk(filt == 1'b0, "R3 bypass follows low", filt, 0);

        // R4 kernel-rate codes
        for (int c = 1; c <= 3; c++) begin
            force_low();
            code = 4'(c);
            steps(3);
            raw = 1'b1;
            n = 0;
            while (filt != 1'b1 && n < 40) begin step(); n++; end
            chk(n == 2 + exp_need(4'(c)), $sformatf("R4 code %0d latency", c), n, 2 + exp_need(4'(c)));
        end

        // R5 R6 divided codes
        for (int c = 4; c <= 15; c++) begin
            force_low();
            code = 4'(c);
            raw = 1'b1;
            steps(4);
            chk(filt == 1'b0, $sformatf("R8 code %0d holds without pulses", c), filt, 0);
            en = 1'b1;
            n = 0;
            while (filt != 1'b1 && n < 400) begin step(); n++; end
            en = 1'b0;
            chk(n == exp_div(4'(c)) * exp_need(4'(c)),
                $sformatf("%s code %0d pulse count", (c <= 9) ? "R5" : "R6", c),
                n, exp_div(4'(c)) * exp_need(4'(c)));
        end

        // R8 long hold without pulses
        force_low();
        code = 4'd12;
        raw = 1'b1;
        steps(200);
        chk(filt == 1'b0, "R8 no pulses no change", filt, 0);

        // R7 broken runs rejected
        force_low();
        code = 4'd3;
        steps(3);
        raw = 1'b1; steps(5);
        raw = 1'b0; step();
        raw = 1'b1; steps(5);
        raw = 1'b0;
        n = 0;
        for (int i = 0; i < 15; i++) begin step(); if (filt) n++; end
        chk(n == 0, "R7 broken run rejected", n, 0);
        raw = 1'b1; steps(7);
        raw = 1'b0; steps(12);
        chk(filt == 1'b0, "R7 seven-sample run rejected", filt, 0);

        // R9 code change holds output, then restarts counting
        code = 4'd0; raw = 1'b1; steps(6);
        code = 4'd3; raw = 1'b0;
        step();
        chk(filt == 1'b1, "R9 output held on code change", filt, 1);
        n = 1;
        while (filt != 1'b0 && n < 40) begin step(); n++; end
        chk(n == 10, "R9 fall latency after change", n, 10);

        // R9 divider and counter restart mid-count
        force_low();
        code = 4'd5;
        raw = 1'b1;
        steps(4);
        en = 1'b1; steps(3); en = 1'b0;
        code = 4'd7;
        steps(2);
        en = 1'b1;
        n = 0;
        while (filt != 1'b1 && n < 100) begin step(); n++; end
        en = 1'b0;
        chk(n == 32, "R9 restart pulse count", n, 32);

        // random phase against the reference model
        force_low();
        steps(2);
        void'($urandom(32'd1234));
        model_on = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 7 == 0) raw = ~raw;
            en = ($urandom % 3 == 0);
            if ($urandom % 300 == 0) code = 4'($urandom % 16);
            step();
        end
        model_on = 1'b0;

        done = 1'b1;
        summary();
    end
endmodule